// File: doc/BRIEF.md
# Freezable Register Sync Bridge

This block carries configuration writes for a pulse-counting core from a fast bus clock domain into the slow clock domain where counting happens. Four registers cross over: a control word, a counter preload value, the active wrap limit (TOP) and a buffered wrap limit. Software writes a register with a strobe, a select code and data. The block keeps the value in a fast-side shadow copy, moves it across with a toggle request and acknowledge handshake, and applies it in the slow domain together with a one-cycle update strobe for that register.

A freeze input lets software gather several writes. While it is high, written values stay in the fast domain. When it drops, every register written in the meantime crosses in one transfer and lands on the same slow clock edge. Each register has its own busy bit, so software can wait on any mask of them. A write to a register that is already in flight is queued and sent afterwards; it is never lost. Bit 0 of the control word, the counter reset enable, also has a direct level-synchronized path that ignores the handshake and the freeze. The buffered limit reaches the active limit a fixed number of slow cycles after it lands.

Top module: `regsync_bridge`

## Requirements
- R1: After reset the slow outputs are: control 0, counter value 0, active and buffered limit all ones, reset enable 0. The busy vector is 0 and frozen status is 0.
- R2: Register select codes are fixed as 0 control, 1 counter value, 2 active limit, 3 buffered limit. When not frozen, a write to an idle bridge appears on the matching slow output, and the matching bit of the update strobe is high for exactly one slow cycle.
- R3: The busy bit of a written register is high in the first fast cycle after the write. It stays high until that value has been applied in the slow domain, and then it returns to 0.
- R4: While freeze is high, no transfer starts, the slow registers keep their values, and busy stays set for every register written during the freeze.
- R5: When freeze falls, all registers written during the freeze are applied on one slow clock edge, shown as one update strobe carrying all of their bits.
- R6: Several writes to the same register during a freeze cross as a single update that carries the last value written.
- R7: If freeze rises while a transfer is in flight, that transfer still completes. The frozen status output goes high only once the acknowledge has returned.
- R8: A write to a register whose busy bit is set is kept and delivered in a later transfer after the current one. The slow side sees the earlier value first and the later value second.
- R9: A write in the same fast cycle as the falling edge of freeze is not part of the batch released by that edge. It crosses in the following transfer.
- R10: A value applied to the buffered limit is copied to the active limit three slow cycles after the edge that applied it. Until then the active limit keeps its old value. A direct active-limit update on the same edge as the copy takes precedence.
- R11: Bit 0 of a control write reaches the reset-enable output through a level synchronizer within four slow cycles, even while frozen. The control register's busy bit is still raised, and the rest of the control word waits for the normal transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_f | input | 1 | Fast bus clock |
| rst_f_n | input | 1 | Fast domain reset, active low, asynchronous assert |
| wr_en | input | 1 | Write strobe, one fast cycle per write |
| wr_sel | input | 2 | Register select code |
| wr_data | input | DW | Write data |
| freeze | input | 1 | Hold writes in the fast domain while high |
| busy | output | 4 | Per-register transfer pending or in flight |
| frz_active | output | 1 | Freeze is high and no transfer is in flight |
| clk_s | input | 1 | Slow counting clock |
| rst_s_n | input | 1 | Slow domain reset, active low, asynchronous assert |
| ctrl_s | output | DW | Control word in the slow domain |
| cnt_s | output | DW | Counter preload value in the slow domain |
| top_s | output | DW | Active wrap limit |
| topbuf_s | output | DW | Buffered wrap limit |
| upd_s | output | 4 | One-cycle per-register apply strobe |
| rsten_s | output | 1 | Counter reset enable, level-synchronized |

## Verification
The interesting collision is a new write landing in the same fast cycle in which a batch is launched. The bench provokes it by dropping freeze and strobing a write to a different register in that single cycle. The scoreboard then expects two transfers in order: the frozen batch alone, then the new write alone. A second overlap, a rewrite of a register whose transfer is still in flight, is judged the same way: the queue must see the earlier value delivered before the later one.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int NREG = 4;
  localparam int SELW = $clog2(NREG);

  typedef enum logic [SELW-1:0] {
    RG_CTRL = 2'd0,
    RG_CNT  = 2'd1,
    RG_TOP  = 2'd2,
    RG_TOPB = 2'd3
  } rsb_reg_e;
endpackage

// File: rtl/rsb_sync2.sv
module rsb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rsb_fast.sv
module rsb_fast
  import rsb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SELW-1:0]          wr_sel,
  input  logic [DW-1:0]            wr_data,
  input  logic                     freeze,
  input  logic                     ack_tgl,
  output logic                     req_tgl,
  output logic [NREG-1:0][DW-1:0]  hold_q,
  output logic [NREG-1:0]          mask_q,
  output logic [NREG-1:0]          busy,
  output logic                     frz_active,
  output logic                     rsten_q
);
  logic                    ack_sy;
  logic                    idle;
  logic                    launch;
  logic [NREG-1:0]         wr_dec;
  logic [NREG-1:0]         dirty_q;
  logic [NREG-1:0]         dirty_d;
  logic [NREG-1:0]         mask_d;
  logic                    req_d;
  logic                    rsten_d;
  logic [NREG-1:0][DW-1:0] shadow_q;

  rsb_sync2 #(.W(1)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_tgl),
    .q     (ack_sy)
  );

  // next-state logic
  always_comb begin
    idle    = (req_tgl == ack_sy);
    launch  = idle && !freeze && (|dirty_q);
    wr_dec  = '0;
    if (wr_en) wr_dec[wr_sel] = 1'b1;
    // a write in the launch cycle stays pending for the next transfer
    dirty_d = (launch ? '0 : dirty_q) | wr_dec;
    mask_d  = launch ? dirty_q : (idle ? '0 : mask_q);
    req_d   = req_tgl ^ launch;
    rsten_d = (wr_en && (wr_sel == RG_CTRL)) ? wr_data[0] : rsten_q;
  end

  // per-register shadow and launch holding copies
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic sh_en;
    logic hd_en;
    assign sh_en = wr_dec[g];
    assign hd_en = launch && dirty_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[g] <= '0;
      end else if (sh_en) begin
        shadow_q[g] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[g] <= '0;
      end else if (hd_en) begin
        hold_q[g] <= shadow_q[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= '0;
      mask_q  <= '0;
      req_tgl <= 1'b0;
      rsten_q <= 1'b0;
    end else begin
      dirty_q <= dirty_d;
      mask_q  <= mask_d;
      req_tgl <= req_d;
      rsten_q <= rsten_d;
    end
  end

  assign busy       = mask_q | dirty_q;
  assign frz_active = freeze && idle;

  AST_FROZEN_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n) freeze |=> $stable(req_tgl)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (req_tgl != ack_sy) |=> $stable(hold_q)); // R5
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> busy[$past(wr_sel)]); // R3
  AST_FRZ_NOT_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n) frz_active |=> !$changed(req_tgl)); // R7
endmodule

// File: rtl/rsb_slow.sv
module rsb_slow
  import rsb_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          TOPB_LAT = 3,
  parameter logic [DW-1:0] TOP_RST = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_tgl,
  input  logic [NREG-1:0][DW-1:0]  hold_q,
  input  logic [NREG-1:0]          mask_q,
  output logic                     ack_tgl,
  output logic [NREG-1:0][DW-1:0]  reg_q,
  output logic [NREG-1:0]          upd_q
);
  logic                 req_sy;
  logic                 apply;
  logic [NREG-1:0]      ld;
  logic [TOPB_LAT-1:0]  tb_pipe_q;
  logic [TOPB_LAT-1:0]  tb_pipe_d;
  logic [TOPB_LAT-1:0]  tb_inj;
  logic                 tb_copy;

  rsb_sync2 #(.W(1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tgl),
    .q     (req_sy)
  );

  always_comb begin
    apply     = (req_sy != ack_tgl);
    ld        = apply ? mask_q : '0;
    tb_inj    = TOPB_LAT'(ld[RG_TOPB]);
    tb_pipe_d = (tb_pipe_q << 1) | tb_inj;
    tb_copy   = tb_pipe_q[TOPB_LAT-1];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RV = ((g == RG_TOP) || (g == RG_TOPB)) ? TOP_RST : '0;
    logic          en;
    logic [DW-1:0] nxt;

    if (g == RG_TOP) begin : g_top
      // direct update wins over the delayed copy from the buffer
      always_comb begin
        en  = ld[g] || tb_copy;
        nxt = ld[g] ? hold_q[g] : reg_q[RG_TOPB];
      end
    end else begin : g_plain
      always_comb begin
        en  = ld[g];
        nxt = hold_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q[g] <= RV;
      end else if (en) begin
        reg_q[g] <= nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl   <= 1'b0;
      upd_q     <= '0;
      tb_pipe_q <= '0;
    end else begin
      ack_tgl   <= req_sy;
      upd_q     <= ld;
      tb_pipe_q <= tb_pipe_d;
    end
  end

  AST_ONE_SHOT_APPLY: assert property (@(posedge clk) disable iff (!rst_n) (|upd_q) |=> (upd_q == '0)); // R2
  AST_TOP_FROM_BUF: assert property (@(posedge clk) disable iff (!rst_n) (tb_copy && !ld[RG_TOP]) |=> (reg_q[RG_TOP] == $past(reg_q[RG_TOPB]))); // R10
  AST_IDLE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n) (!apply && !tb_copy) |=> $stable(reg_q)); // R4
endmodule

// File: rtl/regsync_bridge.sv
module regsync_bridge
  import rsb_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            TOPB_LAT = 3,
  parameter logic [DW-1:0] TOP_RST  = '1
) (
  input  logic              clk_f,
  input  logic              rst_f_n,
  input  logic              wr_en,
  input  logic [SELW-1:0]   wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              freeze,
  output logic [NREG-1:0]   busy,
  output logic              frz_active,
  input  logic              clk_s,
  input  logic              rst_s_n,
  output logic [DW-1:0]     ctrl_s,
  output logic [DW-1:0]     cnt_s,
  output logic [DW-1:0]     top_s,
  output logic [DW-1:0]     topbuf_s,
  output logic [NREG-1:0]   upd_s,
  output logic              rsten_s
);
  logic                    rf_n;
  logic                    rs_n;
  logic                    req_tgl;
  logic                    ack_tgl;
  logic                    rsten_f;
  logic [NREG-1:0]         mask_q;
  logic [NREG-1:0][DW-1:0] hold_q;
  logic [NREG-1:0][DW-1:0] reg_q;

  // reset release synchronizers, one per domain
  rsb_sync2 #(.W(1)) u_rst_f (.clk(clk_f), .rst_n(rst_f_n), .d(1'b1), .q(rf_n));
  rsb_sync2 #(.W(1)) u_rst_s (.clk(clk_s), .rst_n(rst_s_n), .d(1'b1), .q(rs_n));

  rsb_fast #(.DW(DW)) u_fast (
    .clk        (clk_f),
    .rst_n      (rf_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .freeze     (freeze),
    .ack_tgl    (ack_tgl),
    .req_tgl    (req_tgl),
    .hold_q     (hold_q),
    .mask_q     (mask_q),
    .busy       (busy),
    .frz_active (frz_active),
    .rsten_q    (rsten_f)
  );

  rsb_slow #(.DW(DW), .TOPB_LAT(TOPB_LAT), .TOP_RST(TOP_RST)) u_slow (
    .clk     (clk_s),
    .rst_n   (rs_n),
    .req_tgl (req_tgl),
    .hold_q  (hold_q),
    .mask_q  (mask_q),
    .ack_tgl (ack_tgl),
    .reg_q   (reg_q),
    .upd_q   (upd_s)
  );

  // reset-enable side path: level synchronized, independent of the handshake
  rsb_sync2 #(.W(1)) u_rsten (.clk(clk_s), .rst_n(rs_n), .d(rsten_f), .q(rsten_s));

  assign ctrl_s   = reg_q[RG_CTRL];
  assign cnt_s    = reg_q[RG_CNT];
  assign top_s    = reg_q[RG_TOP];
  assign topbuf_s = reg_q[RG_TOPB];
endmodule

// File: tb/sim_regsync_bridge.sv
`timescale 1ns/100ps
module sim_regsync_bridge;
  localparam int DW = 16;

  typedef struct packed {
    logic [3:0]         m;
    logic [3:0][DW-1:0] v;
  } batch_t;

  logic          clk_f = 1'b0;
  logic          clk_s = 1'b0;
  logic          rst_f_n, rst_s_n;
  logic          wr_en, freeze;
  logic [1:0]    wr_sel;
  logic [DW-1:0] wr_data;
  logic [3:0]    busy, upd_s;
  logic          frz_active, rsten_s;
  logic [DW-1:0] ctrl_s, cnt_s, top_s, topbuf_s;

  int n_run = 0;
  int n_fail = 0;
  int ndel = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  batch_t exp_q[$];
  logic [3:0][DW-1:0] wv;

  // top-buffer follow tracking
  bit tb_on = 1'b0;
  int tb_k = 0;
  logic [DW-1:0] tb_v, tb_old;

  always #4 clk_f = ~clk_f;
  always #18.5 clk_s = ~clk_s;

  regsync_bridge #(.DW(DW)) u0 (
    .clk_f(clk_f), .rst_f_n(rst_f_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .freeze(freeze), .busy(busy), .frz_active(frz_active), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .ctrl_s(ctrl_s), .cnt_s(cnt_s), .top_s(top_s), .topbuf_s(topbuf_s), .upd_s(upd_s),
    .rsten_s(rsten_s)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // driver: one write, model update
  task automatic wr(input int sel, input logic [DW-1:0] d);
    @(negedge clk_f);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
    @(negedge clk_f);
    wr_en = 1'b0;
    wv[sel] = d;
  endtask

  task automatic push(input logic [3:0] m);
    batch_t b;
    b.m = m; b.v = wv;
    exp_q.push_back(b);
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_f);
      if (busy == 4'b0) break;
    end
    check(busy == 4'b0, req, 32'(busy), 32'h0);
  endtask

  task automatic wait_slow(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_s);
  endtask

  // monitor: pops expected batches as the design applies them
  always @(negedge clk_s) begin
    if (mon_on) begin
      if (tb_on) begin
        tb_k++;
        if (tb_k == 2) check(top_s == tb_old, "R10 active limit before copy", 32'(top_s), 32'(tb_old));
        if (tb_k == 3) begin
          check(top_s == tb_v, "R10 active limit after copy", 32'(top_s), 32'(tb_v));
          tb_on = 1'b0;
        end
      end
      if (upd_s != 4'b0) begin
        ndel++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected update", 32'(upd_s), 32'h0);
        end else begin
          batch_t b;
          b = exp_q.pop_front();
          check(upd_s == b.m, "R5 update mask", 32'(upd_s), 32'(b.m));
          if (b.m[0]) check(ctrl_s == b.v[0], "R2 control value", 32'(ctrl_s), 32'(b.v[0]));
          if (b.m[1]) check(cnt_s == b.v[1], "R2 counter value", 32'(cnt_s), 32'(b.v[1]));
          if (b.m[2]) check(top_s == b.v[2], "R2 limit value", 32'(top_s), 32'(b.v[2]));
          if (b.m[3]) begin
            check(topbuf_s == b.v[3], "R2 buffered limit value", 32'(topbuf_s), 32'(b.v[3]));
            tb_on = 1'b1; tb_k = 0; tb_v = b.v[3]; tb_old = top_s;
          end
        end
      end
    end
  end

  initial begin
    #1000000;
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    int n0;
    rst_f_n = 1'b0; rst_s_n = 1'b0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; freeze = 1'b0;
    wv[0] = '0; wv[1] = '0; wv[2] = '1; wv[3] = '1;
    #100;
    rst_f_n = 1'b1; rst_s_n = 1'b1;
    wait_slow(6);
    mon_on = 1'b1;

    // R1 reset state
    check(busy == 4'b0, "R1 busy", 32'(busy), 32'h0);
    check(frz_active == 1'b0, "R1 frozen status", 32'(frz_active), 32'h0);
    check(ctrl_s == '0 && cnt_s == '0, "R1 control and counter", {ctrl_s, cnt_s}, 32'h0);
    check(top_s == 16'hFFFF && topbuf_s == 16'hFFFF, "R1 limits", {top_s, topbuf_s}, 32'hFFFFFFFF);
    check(rsten_s == 1'b0, "R1 reset enable", 32'(rsten_s), 32'h0);

    // R2 / R3 single unfrozen writes
    n0 = ndel;
    wr(1, 16'h1234); push(4'b0010);
    check(busy[1] == 1'b1, "R3 busy after write", 32'(busy), 32'h2);
    wait_idle("R3 busy clears");
    check(ndel == n0 + 1, "R3 delivered before busy clear", 32'(ndel), 32'(n0 + 1));
    check(cnt_s == 16'h1234, "R2 counter output", 32'(cnt_s), 32'h1234);
    wr(0, 16'h00A4); push(4'b0001); wait_idle("R2 control idle");
    wr(2, 16'h0300); push(4'b0100); wait_idle("R2 limit idle");
    check(top_s == 16'h0300, "R2 limit output", 32'(top_s), 32'h0300);

    // R10 buffered limit follows after three slow cycles
    wr(3, 16'h0055); push(4'b1000); wait_idle("R10 idle");
    wait_slow(5);
    check(top_s == 16'h0055, "R10 limit settled", 32'(top_s), 32'h0055);

    // R4 / R5 freeze gathers writes, release is atomic
    @(negedge clk_f); freeze = 1'b1;
    n0 = ndel;
    wr(0, 16'h0010); wr(1, 16'h0777); wr(3, 16'h0123);
    wait_slow(20);
    check(ndel == n0, "R4 nothing delivered while frozen", 32'(ndel), 32'(n0));
    check(busy == 4'b1011, "R4 busy while frozen", 32'(busy), 32'hB);
    check(cnt_s == 16'h1234, "R4 slow value held", 32'(cnt_s), 32'h1234);
    check(frz_active == 1'b1, "R7 frozen status when idle", 32'(frz_active), 32'h1);
    push(4'b1011);
    @(negedge clk_f); freeze = 1'b0;
    wait_idle("R5 idle");
    check(ndel == n0 + 1, "R5 single update", 32'(ndel), 32'(n0 + 1));
    wait_slow(5);

    // R6 last value wins
    @(negedge clk_f); freeze = 1'b1;
    n0 = ndel;
    wr(1, 16'h0AAA); wr(1, 16'h0BBB);
    push(4'b0010);
    @(negedge clk_f); freeze = 1'b0;
    wait_idle("R6 idle");
    check(ndel == n0 + 1, "R6 one update", 32'(ndel), 32'(n0 + 1));
    check(cnt_s == 16'h0BBB, "R6 last value", 32'(cnt_s), 32'h0BBB);

    // R8 rewrite while in flight
    n0 = ndel;
    wr(1, 16'h1111); push(4'b0010);
    wr(1, 16'h2222); push(4'b0010);
    wait_idle("R8 idle");
    check(ndel == n0 + 2, "R8 both delivered", 32'(ndel), 32'(n0 + 2));
    check(cnt_s == 16'h2222, "R8 later value last", 32'(cnt_s), 32'h2222);

    // R9 write in the release cycle goes in the next transfer
    @(negedge clk_f); freeze = 1'b1;
    n0 = ndel;
    wr(2, 16'h0400); push(4'b0100);
    @(negedge clk_f);
    freeze = 1'b0; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h3333;
    @(negedge clk_f);
    wr_en = 1'b0; wv[1] = 16'h3333; push(4'b0010);
    wait_idle("R9 idle");
    check(ndel == n0 + 2, "R9 two transfers", 32'(ndel), 32'(n0 + 2));
    check(top_s == 16'h0400 && cnt_s == 16'h3333, "R9 values", {top_s, cnt_s}, 32'h04003333);

    // R7 freeze raised during a transfer
    wr(0, 16'h0020); push(4'b0001);
    @(negedge clk_f); freeze = 1'b1;
    check(frz_active == 1'b0, "R7 not frozen while in flight", 32'(frz_active), 32'h0);
    for (int i = 0; i < 3000; i++) begin
      if (frz_active) break;
      @(negedge clk_f);
    end
    check(ctrl_s == 16'h0020, "R7 in-flight transfer completed", 32'(ctrl_s), 32'h0020);
    @(negedge clk_f); freeze = 1'b0;
    wait_idle("R7 idle");

    // R11 reset-enable side path bypasses freeze
    @(negedge clk_f); freeze = 1'b1;
    wr(0, 16'h0021);
    wait_slow(5);
    check(rsten_s == 1'b1, "R11 reset enable through", 32'(rsten_s), 32'h1);
    check(busy[0] == 1'b1, "R11 busy still raised", 32'(busy), 32'h1);
    check(ctrl_s == 16'h0020, "R11 rest of control held", 32'(ctrl_s), 32'h0020);
    push(4'b0001);
    @(negedge clk_f); freeze = 1'b0;
    wait_idle("R11 idle");
    check(ctrl_s == 16'h0021, "R11 control after release", 32'(ctrl_s), 32'h0021);

    wait_slow(6);
    check(exp_q.size() == 0, "R2 all expected updates seen", 32'(exp_q.size()), 32'h0);
    summary();
  end
endmodule